// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a first-generation DDR SDRAM from power-up to a usable state. It waits in an idle state until a start pulse arrives. It then holds the clock-enable pin low and sends only no-operation commands for a power-up wait whose length is a parameter. After that it raises clock enable and issues a fixed chain of commands. Between any two commands it inserts the minimum gap that the first command requires. When the last gap has run out, it raises a done flag and a refresh-enable flag. Both stay high until reset.

While the chain runs, the block also counts the DLL lock time that starts with the mode-register write that resets the DLL. It keeps a read-permission output low until that count has run out. Software supplies the mode-register code and the extended-mode code on input ports. The sequencer sets or clears the DLL-reset bit itself. Data-path signalling, periodic refresh and memory scrubbing belong to other blocks.

States: IDLE, PWRUP, PRE_A, EMRS, MRS_DLL, PRE_B, AR_A, AR_B, MRS_RUN, TAIL, DONE. Transitions: IDLE to PWRUP on start. PWRUP to PRE_A when the power-up wait expires, which also raises clock enable. Each command state issues its command once the gap counter is zero and then moves to the next state in the list. TAIL moves to DONE when the final gap expires. DONE is left only by reset.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset and until a start pulse, cke is low, done, read_ok and refresh_en are low, and the command bus shows NOP. Commands are coded on {cs_n,ras_n,cas_n,we_n} as NOP=0111, PRE=0010, AR=0001, MRS/EMRS=0000 and ACT=0011.
- R2: Let cycle 0 be the first cycle after the edge that accepts start. cke is low and the bus is NOP in cycles 0 to PWRUP_CYC-1. cke is high from cycle PWRUP_CYC onward.
- R3: The commands come in this order: PRE, EMRS, MRS (DLL reset), PRE, AR, AR, MRS. The first PRE is in cycle PWRUP_CYC+1. Every other cycle shows NOP with ba=0 and addr=0.
- R4: EMRS drives ba=2'b01 (ba[0] high, ba[1] low) and addr=ext_code. Both MRS commands drive ba=2'b00.
- R5: Each PRE drives addr with only bit 10 set, which selects all banks, and ba=0. Each AR drives addr=0 and ba=0.
- R6: The first MRS drives mode_code with bit 8 forced to 1. The final MRS drives mode_code with bit 8 forced to 0.
- R7: The start of the next command follows the start of each PRE by exactly T_RP cycles, each EMRS or MRS by exactly T_MRD cycles, and each AR by exactly T_RFC cycles. Each command lasts one cycle.
- R8: done and refresh_en rise exactly T_MRD cycles after the final MRS and stay high until reset.
- R9: read_ok rises exactly LOCK_CYC cycles after the DLL-reset MRS and stays high until reset.
- R10: A start pulse is ignored while the sequence runs and after done is set.
- R11: Reset asserted in the middle of the sequence returns the block to the R1 idle state. A later start then runs the full sequence again from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins initialization |
| mode_code | input | ADDR_W | Mode-register code (bit 8 is overridden by the block) |
| ext_code | input | ADDR_W | Extended-mode-register code |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus; bit 10 selects all banks for PRE |
| done | output | 1 | Initialization complete, so row-activate is allowed |
| read_ok | output | 1 | DLL lock time has elapsed, so reads are allowed |
| refresh_en | output | 1 | Periodic refresh may run |

## Verification
Two functions can change an output in the same cycle: the DLL lock timer and the command chain. The bench sets LOCK_CYC so that read_ok rises in exactly the cycle in which done and refresh_en rise. A reference model built on cycle offsets judges both events independently in that shared cycle. A stray start pulse in the middle of the chain, and another one after done, test that neither event can shift the command schedule.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PRE_B,
        ST_AR_A,
        ST_AR_B,
        ST_MRS_RUN,
        ST_TAIL,
        ST_DONE
    } ddr_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_AR  = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    localparam int DLL_RST_BIT = 8;
    localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  ddr_state_e        st,
    input  logic [ADDR_W-1:0] mode_code,
    input  logic [ADDR_W-1:0] ext_code,
    output ddr_cmd_e          cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] dll_mask;

    always_comb begin
        dll_mask = '0;
        dll_mask[DLL_RST_BIT] = 1'b1;
        cmd  = CMD_NOP;
        ba   = 2'b00;
        addr = '0;
        unique case (st)
            ST_PRE_A, ST_PRE_B: begin
                cmd = CMD_PRE;
                addr[ALL_BANK_BIT] = 1'b1;
            end
            ST_EMRS: begin
                cmd  = CMD_MRS;
                ba   = 2'b01;
                addr = ext_code;
            end
            ST_MRS_DLL: begin
                cmd  = CMD_MRS;
                addr = mode_code | dll_mask;
            end
            ST_MRS_RUN: begin
                cmd  = CMD_MRS;
                addr = mode_code & ~dll_mask;
            end
            ST_AR_A, ST_AR_B: cmd = CMD_AR;
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PWRUP_CYC = 40000,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 14,
    parameter int LOCK_CYC  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] mode_code,
    input  logic [ADDR_W-1:0] ext_code,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              read_ok,
    output logic              refresh_en
);
    localparam int GAP_MAX1 = (PWRUP_CYC > T_RFC) ? PWRUP_CYC : T_RFC;
    localparam int GAP_MAX2 = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int GAP_MAX  = (GAP_MAX1 > GAP_MAX2) ? GAP_MAX1 : GAP_MAX2;
    localparam int GAP_W    = $clog2(GAP_MAX + 1);
    localparam int LOCK_W   = $clog2(LOCK_CYC + 1);

    ddr_state_e state_q, state_d;
    logic       gap_zero, gap_load, lock_zero, lock_load, lock_arm_q;
    logic       is_cmd_st, issue;
    logic [GAP_W-1:0] gap_val;
    ddr_cmd_e   enc_cmd;
    logic [1:0] enc_ba;
    logic [ADDR_W-1:0] enc_addr;
    logic [3:0] cmd_q;

    assign is_cmd_st = (state_q == ST_PRE_A)  || (state_q == ST_EMRS)  ||
                       (state_q == ST_MRS_DLL) || (state_q == ST_PRE_B) ||
                       (state_q == ST_AR_A)   || (state_q == ST_AR_B)  ||
                       (state_q == ST_MRS_RUN);
    assign issue     = is_cmd_st && gap_zero;

    // gap reload value chosen by the command about to leave
    always_comb begin
        unique case (state_q)
            ST_IDLE:                       gap_val = GAP_W'(PWRUP_CYC - 1);
            ST_PRE_A, ST_PRE_B:            gap_val = GAP_W'(T_RP - 1);
            ST_AR_A, ST_AR_B:              gap_val = GAP_W'(T_RFC - 1);
            ST_EMRS, ST_MRS_DLL, ST_MRS_RUN: gap_val = GAP_W'(T_MRD - 1);
            default:                       gap_val = '0;
        endcase
    end

    assign gap_load  = ((state_q == ST_IDLE) && start) || issue;
    assign lock_load = issue && (state_q == ST_MRS_DLL);

    ddr_init_cnt #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .val(gap_val), .zero(gap_zero)
    );

    ddr_init_cnt #(.W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .load(lock_load),
        .val(LOCK_W'(LOCK_CYC - 1)), .zero(lock_zero)
    );

    ddr_init_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
        .st(state_q), .mode_code(mode_code), .ext_code(ext_code),
        .cmd(enc_cmd), .ba(enc_ba), .addr(enc_addr)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)    state_d = ST_PWRUP;
            ST_PWRUP:   if (gap_zero) state_d = ST_PRE_A;
            ST_PRE_A:   if (issue)    state_d = ST_EMRS;
            ST_EMRS:    if (issue)    state_d = ST_MRS_DLL;
            ST_MRS_DLL: if (issue)    state_d = ST_PRE_B;
            ST_PRE_B:   if (issue)    state_d = ST_AR_A;
            ST_AR_A:    if (issue)    state_d = ST_AR_B;
            ST_AR_B:    if (issue)    state_d = ST_MRS_RUN;
            ST_MRS_RUN: if (issue)    state_d = ST_TAIL;
            ST_TAIL:    if (gap_zero) state_d = ST_DONE;
            ST_DONE:                  state_d = ST_DONE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= CMD_NOP;
            ba         <= 2'b00;
            addr       <= '0;
            cke        <= 1'b0;
            done       <= 1'b0;
            read_ok    <= 1'b0;
            lock_arm_q <= 1'b0;
        end else begin
            cmd_q <= issue ? enc_cmd  : CMD_NOP;
            ba    <= issue ? enc_ba   : 2'b00;
            addr  <= issue ? enc_addr : '0;
            if ((state_q == ST_PWRUP) && gap_zero) cke <= 1'b1;
            if ((state_q == ST_TAIL) && gap_zero)  done <= 1'b1;
            if (lock_load) lock_arm_q <= 1'b1;
            if (lock_arm_q && lock_zero && !lock_load) read_ok <= 1'b1;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign refresh_en = done;
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              cke,
    input logic [1:0]        ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done,
    input logic              read_ok
);
    logic [3:0] bus;
    assign bus = {cs_n, ras_n, cas_n, we_n};

    a_r2_nop_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> bus == 4'b0111);
    a_r7_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus != 4'b0111 |=> bus == 4'b0111);
    a_r5_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        bus == 4'b0010 |-> addr[10]);
    a_r4_mode_bank: assert property (@(posedge clk) disable iff (!rst_n)
        bus == 4'b0000 |-> (ba == 2'b00 || ba == 2'b01));
    a_r3_no_activate: assert property (@(posedge clk) disable iff (!rst_n)
        bus != 4'b0011);
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    a_r8_done_cke: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cke);
    a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok |=> read_ok);
endmodule

bind ddr_init_seq ddr_init_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .done(done), .read_ok(read_ok)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
    localparam int AW = 13, PW = 20, TRP = 3, TMRD = 2, TRFC = 5, LOCK = 17;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] mode_code = '0, ext_code = '0;
    logic cs_n, ras_n, cas_n, we_n, cke, done, read_ok, refresh_en;
    logic [1:0] ba;
    logic [AW-1:0] addr;

    int total = 0, bad = 0, cycles = 0;
    bit run = 1'b0;
    int k = 0;
    string ctx = "R1";

    always #5 clk = ~clk;

    ddr_init_seq #(.ADDR_W(AW), .PWRUP_CYC(PW), .T_RP(TRP), .T_MRD(TMRD),
                   .T_RFC(TRFC), .LOCK_CYC(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mode_code),
        .ext_code(ext_code), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .done(done),
        .read_ok(read_ok), .refresh_en(refresh_en)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] k=%0d actual=%h expected=%h", req, ctx, k, act, exp);
        end
    endtask

    // behavioural reference: cycle offset since the accepting edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) run = 1'b0;
        else if (run) k++;
        else if (start) begin run = 1'b1; k = 0; end
    end

    always @(negedge clk) begin
        int e0, e1, e2, e3, e4, e5, e6;
        logic [3:0] xc; logic [1:0] xb; logic [AW-1:0] xa;
        logic [AW-1:0] m8;
        m8 = '0; m8[8] = 1'b1;
        e0 = PW + 1; e1 = e0 + TRP; e2 = e1 + TMRD; e3 = e2 + TMRD;
        e4 = e3 + TRP; e5 = e4 + TRFC; e6 = e5 + TRFC;
        xc = 4'b0111; xb = 2'b00; xa = '0;
        if (run) begin
            if (k == e0 || k == e3) begin xc = 4'b0010; xa = '0; xa[10] = 1'b1; end
            if (k == e1) begin xc = 4'b0000; xb = 2'b01; xa = ext_code; end
            if (k == e2) begin xc = 4'b0000; xa = mode_code | m8; end
            if (k == e4 || k == e5) xc = 4'b0001;
            if (k == e6) begin xc = 4'b0000; xa = mode_code & ~m8; end
        end
        if (rst_n) begin
            chk("R3/R7 cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, xc});
            chk("R4 ba", {30'd0, ba}, {30'd0, xb});
            chk("R5/R6 addr", {19'd0, addr}, {19'd0, xa});
            chk("R2 cke", {31'd0, cke}, {31'd0, (run && k >= PW)});
            chk("R8 done", {31'd0, done}, {31'd0, (run && k >= e6 + TMRD)});
            chk("R8 refresh_en", {31'd0, refresh_en}, {31'd0, (run && k >= e6 + TMRD)});
            chk("R9 read_ok", {31'd0, read_ok}, {31'd0, (run && k >= e2 + LOCK)});
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        ctx = "R1";
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R1 idle cke", {31'd0, cke}, 32'd0);
        chk("R1 idle done", {31'd0, done}, 32'd0);
        // run 1: DLL bit clear in supplied code
        mode_code = 13'h0032; ext_code = 13'h0002;
        ctx = "main";
        pulse_start();
        wait_cyc(10);
        ctx = "R10 busy";
        pulse_start();
        wait_cyc(60);
        chk("R8 done after run", {31'd0, done}, 32'd1);
        ctx = "R10 after done";
        pulse_start();
        wait_cyc(15);
        // run 2: DLL bit set in supplied code, reset in the middle
        @(negedge clk) rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        mode_code = 13'h1FFF; ext_code = 13'h0000;
        ctx = "main2";
        pulse_start();
        wait_cyc(30);
        ctx = "R11";
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R11 cke after reset", {31'd0, cke}, 32'd0);
        chk("R11 read_ok after reset", {31'd0, read_ok}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(5);
        mode_code = 13'h0155; ext_code = 13'h1003;
        pulse_start();
        wait_cyc(70);
        chk("R11 rerun done", {31'd0, done}, 32'd1);
        chk("R9 rerun read_ok", {31'd0, read_ok}, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule